// File: doc/BRIEF.md
# Secure/Non-Secure Access Filter

This block sits on the path from one bus master to memory and keeps the secure and normal address spaces apart. Every request carries an address, a read/write flag, write data and a protection field. One bit of that field is the non-secure attribute, and it names the space the access targets. A separate input gives the world the master is running in at that moment.

A secure-world master may reach either space. A normal-world master may reach only normal space. When a request is legal, the filter issues it downstream with the non-secure attribute placed above the address as an extra address bit. The same 32-bit address in the two worlds therefore lands in two separate locations.

A request from a normal-world master aimed at secure space never leaves the filter. It is answered with an error and zero read data on the cycle after acceptance. It also raises a violation strobe and captures the offending address. The filter keeps at most one transaction in flight.

Top module: `sec_bus_filter`

## Requirements
- R1: While reset is asserted and right after it, `up_ready` is 1, `dn_valid`, `rsp_valid` and `viol_pulse` are 0, and `viol_addr` is 0.
- R2: A forwarded request appears on `dn_addr` as the upstream address with the non-secure attribute (bit 1 of `up_prot`, 1 = normal space, 0 = secure space) as bit 32. The cycle after acceptance, `dn_valid` is 1.
- R3: With `world_ns` = 0 (secure master), requests with either value of the non-secure attribute are forwarded. Reads return the data last written to the same 33-bit downstream location, so 0x8000 in secure space and 0x8000 in normal space hold independent values.
- R4: With `world_ns` = 1 (normal master), a request with the non-secure attribute at 1 is forwarded and reads normal-space data.
- R5: With `world_ns` = 1 and the non-secure attribute at 0, no downstream transfer occurs, and secure-space contents are unchanged. In the cycle after acceptance, `rsp_valid` = 1, `rsp_err` = 1 and `rsp_rdata` = 0.
- R6: Each rejected request raises `viol_pulse` for exactly the cycle after acceptance and loads `viol_addr` with its address. `viol_addr` holds its value across later legal traffic.
- R7: For a forwarded request, the upstream response comes one cycle after `dn_rsp_valid`, with `dn_rsp_rdata` and `dn_rsp_err` copied to `rsp_rdata` and `rsp_err`.
- R8: While `dn_valid` is 1 and `dn_ready` is 0, `dn_valid` stays 1 and the downstream address, write flag and write data are held.
- R9: Only one transaction is in flight at a time. `up_ready` is 0 from acceptance of a forwarded request until its response is returned.
- R10: The write flag, the write data and the full protection field of a forwarded request reach `dn_write`, `dn_wdata` and `dn_prot` unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| world_ns | input | 1 | Master's current world: 1 normal, 0 secure |
| up_valid | input | 1 | Upstream request valid |
| up_ready | output | 1 | Filter can take a request |
| up_addr | input | ADDR_W | Request address |
| up_prot | input | PROT_W | Protection field; bit NS_POS is the non-secure attribute |
| up_write | input | 1 | 1 write, 0 read |
| up_wdata | input | DATA_W | Write data |
| dn_valid | output | 1 | Downstream request valid |
| dn_ready | input | 1 | Downstream accepts request |
| dn_addr | output | ADDR_W+1 | Address with the non-secure attribute on top |
| dn_prot | output | PROT_W | Forwarded protection field |
| dn_write | output | 1 | Forwarded write flag |
| dn_wdata | output | DATA_W | Forwarded write data |
| dn_rsp_valid | input | 1 | Downstream response valid |
| dn_rsp_rdata | input | DATA_W | Downstream read data |
| dn_rsp_err | input | 1 | Downstream error |
| rsp_valid | output | 1 | Upstream response valid |
| rsp_rdata | output | DATA_W | Upstream read data |
| rsp_err | output | 1 | Upstream error |
| viol_pulse | output | 1 | One-cycle strobe per rejected access |
| viol_addr | output | ADDR_W | Address of the latest rejected access |

## Verification
The bench keeps the default values: 32-bit address and data, a 3-bit protection field, and the non-secure attribute at bit 1. With these values the downstream address is 33 bits, and the bench models memory keyed by that full value. Accesses to the same low address from both worlds (0x8000 in particular) therefore show directly whether the two spaces alias or stay apart. The random downstream ready delay exercises the hold behaviour under stalls. Addresses at the top of the range trigger downstream errors, which must come back to the master unchanged.

// File: rtl/sbf_pkg.sv
package sbf_pkg;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_ISSUE = 2'd1,
    ST_WAIT  = 2'd2
  } sbf_state_e;

  // A normal-world master may only target normal space.
  function automatic logic access_allowed(input logic master_ns, input logic target_ns);
    return (!master_ns) || target_ns;
  endfunction

endpackage

// File: rtl/sbf_access_check.sv
module sbf_access_check #(
  parameter int PROT_W = 3,
  parameter int NS_POS = 1
) (
  input  logic              world_ns,
  input  logic [PROT_W-1:0] prot,
  output logic              target_ns,
  output logic              allowed
);
  import sbf_pkg::*;

  always_comb begin
    target_ns = prot[NS_POS];
    allowed   = access_allowed(world_ns, prot[NS_POS]);
  end

endmodule

// File: rtl/sbf_req_path.sv
module sbf_req_path #(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32,
  parameter int PROT_W = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              up_valid,
  output logic              up_ready,
  input  logic [ADDR_W-1:0] up_addr,
  input  logic [PROT_W-1:0] up_prot,
  input  logic              up_write,
  input  logic [DATA_W-1:0] up_wdata,
  input  logic              allowed,
  input  logic              target_ns,
  output logic              accept_evt,
  output logic              reject_evt,
  output logic              dn_valid,
  input  logic              dn_ready,
  output logic [ADDR_W:0]   dn_addr,
  output logic [PROT_W-1:0] dn_prot,
  output logic              dn_write,
  output logic [DATA_W-1:0] dn_wdata,
  input  logic              dn_rsp_valid,
  input  logic [DATA_W-1:0] dn_rsp_rdata,
  input  logic              dn_rsp_err,
  output logic              rsp_valid,
  output logic [DATA_W-1:0] rsp_rdata,
  output logic              rsp_err
);
  import sbf_pkg::*;

  localparam int DN_AW = ADDR_W + 1;

  function automatic logic [DN_AW-1:0] extend_addr(input logic ns, input logic [ADDR_W-1:0] a);
    return {ns, a};
  endfunction

  sbf_state_e state_q;

  always_comb begin
    up_ready   = (state_q == ST_IDLE);
    accept_evt = up_valid && up_ready;
    reject_evt = accept_evt && !allowed;
    dn_valid   = (state_q == ST_ISSUE);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q   <= ST_IDLE;
      dn_addr   <= '0;
      dn_prot   <= '0;
      dn_write  <= 1'b0;
      dn_wdata  <= '0;
      rsp_valid <= 1'b0;
      rsp_rdata <= '0;
      rsp_err   <= 1'b0;
    end else begin
      rsp_valid <= 1'b0;
      unique case (state_q)
        ST_IDLE: begin
          if (accept_evt) begin
            if (allowed) begin
              dn_addr  <= extend_addr(target_ns, up_addr);
              dn_prot  <= up_prot;
              dn_write <= up_write;
              dn_wdata <= up_wdata;
              state_q  <= ST_ISSUE;
            end else begin
              rsp_valid <= 1'b1;
              rsp_err   <= 1'b1;
              rsp_rdata <= '0;
            end
          end
        end
        ST_ISSUE: begin
          if (dn_ready) state_q <= ST_WAIT;
        end
        ST_WAIT: begin
          if (dn_rsp_valid) begin
            rsp_valid <= 1'b1;
            rsp_rdata <= dn_rsp_rdata;
            rsp_err   <= dn_rsp_err;
            state_q   <= ST_IDLE;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/sbf_viol_capture.sv
module sbf_viol_capture #(
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reject_evt,
  input  logic [ADDR_W-1:0] addr,
  output logic              viol_pulse,
  output logic [ADDR_W-1:0] viol_addr
);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      viol_pulse <= 1'b0;
      viol_addr  <= '0;
    end else begin
      viol_pulse <= reject_evt;
      if (reject_evt) viol_addr <= addr;
    end
  end

endmodule

// File: rtl/sec_bus_filter.sv
module sec_bus_filter #(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32,
  parameter int PROT_W = 3,
  parameter int NS_POS = 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              world_ns,
  input  logic              up_valid,
  output logic              up_ready,
  input  logic [ADDR_W-1:0] up_addr,
  input  logic [PROT_W-1:0] up_prot,
  input  logic              up_write,
  input  logic [DATA_W-1:0] up_wdata,
  output logic              dn_valid,
  input  logic              dn_ready,
  output logic [ADDR_W:0]   dn_addr,
  output logic [PROT_W-1:0] dn_prot,
  output logic              dn_write,
  output logic [DATA_W-1:0] dn_wdata,
  input  logic              dn_rsp_valid,
  input  logic [DATA_W-1:0] dn_rsp_rdata,
  input  logic              dn_rsp_err,
  output logic              rsp_valid,
  output logic [DATA_W-1:0] rsp_rdata,
  output logic              rsp_err,
  output logic              viol_pulse,
  output logic [ADDR_W-1:0] viol_addr
);

  // Named internal events, observed by the bound checker.
  logic target_ns;
  logic allowed;
  logic accept_evt;
  logic reject_evt;

  sbf_access_check #(.PROT_W(PROT_W), .NS_POS(NS_POS)) chk_u (
    .world_ns  (world_ns),
    .prot      (up_prot),
    .target_ns (target_ns),
    .allowed   (allowed)
  );

  sbf_req_path #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .PROT_W(PROT_W)) path_u (
    .clk          (clk),
    .rst_n        (rst_n),
    .up_valid     (up_valid),
    .up_ready     (up_ready),
    .up_addr      (up_addr),
    .up_prot      (up_prot),
    .up_write     (up_write),
    .up_wdata     (up_wdata),
    .allowed      (allowed),
    .target_ns    (target_ns),
    .accept_evt   (accept_evt),
    .reject_evt   (reject_evt),
    .dn_valid     (dn_valid),
    .dn_ready     (dn_ready),
    .dn_addr      (dn_addr),
    .dn_prot      (dn_prot),
    .dn_write     (dn_write),
    .dn_wdata     (dn_wdata),
    .dn_rsp_valid (dn_rsp_valid),
    .dn_rsp_rdata (dn_rsp_rdata),
    .dn_rsp_err   (dn_rsp_err),
    .rsp_valid    (rsp_valid),
    .rsp_rdata    (rsp_rdata),
    .rsp_err      (rsp_err)
  );

  sbf_viol_capture #(.ADDR_W(ADDR_W)) viol_u (
    .clk        (clk),
    .rst_n      (rst_n),
    .reject_evt (reject_evt),
    .addr       (up_addr),
    .viol_pulse (viol_pulse),
    .viol_addr  (viol_addr)
  );

endmodule

// File: rtl/sbf_checker.sv
module sbf_checker #(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32,
  parameter int PROT_W = 3,
  parameter int NS_POS = 1
) (
  input logic              clk,
  input logic              rst_n,
  input logic              up_ready,
  input logic [ADDR_W-1:0] up_addr,
  input logic [PROT_W-1:0] up_prot,
  input logic              dn_valid,
  input logic              dn_ready,
  input logic [ADDR_W:0]   dn_addr,
  input logic              dn_write,
  input logic [DATA_W-1:0] dn_wdata,
  input logic              dn_rsp_valid,
  input logic              rsp_valid,
  input logic              rsp_err,
  input logic [DATA_W-1:0] rsp_rdata,
  input logic              viol_pulse,
  input logic [ADDR_W-1:0] viol_addr,
  input logic              accept_evt,
  input logic              reject_evt
);

  AST_FWD_ADDR_EXT: assert property (@(posedge clk) disable iff (!rst_n)
    (accept_evt && !reject_evt) |=> (dn_valid && dn_addr == {$past(up_prot[NS_POS]), $past(up_addr)})); // R2

  AST_BLOCK_NO_ISSUE: assert property (@(posedge clk) disable iff (!rst_n)
    reject_evt |=> !dn_valid); // R5

  AST_BLOCK_ERR_RSP: assert property (@(posedge clk) disable iff (!rst_n)
    reject_evt |=> (rsp_valid && rsp_err && rsp_rdata == '0)); // R5

  AST_VIOL_ON_REJECT: assert property (@(posedge clk) disable iff (!rst_n)
    reject_evt |=> (viol_pulse && viol_addr == $past(up_addr))); // R6

  AST_VIOL_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !reject_evt |=> (!viol_pulse && $stable(viol_addr))); // R6

  AST_RSP_FOLLOWS_DN: assert property (@(posedge clk) disable iff (!rst_n)
    (dn_rsp_valid && !dn_valid && !up_ready) |=> rsp_valid); // R7

  AST_DN_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (dn_valid && !dn_ready) |=> (dn_valid && $stable(dn_addr) && $stable(dn_write) && $stable(dn_wdata))); // R8

  AST_SINGLE_OUTSTANDING: assert property (@(posedge clk) disable iff (!rst_n)
    dn_valid |-> !up_ready); // R9

endmodule

bind sec_bus_filter sbf_checker #(
  .ADDR_W(ADDR_W), .DATA_W(DATA_W), .PROT_W(PROT_W), .NS_POS(NS_POS)
) sbf_chk_i (
  .clk          (clk),
  .rst_n        (rst_n),
  .up_ready     (up_ready),
  .up_addr      (up_addr),
  .up_prot      (up_prot),
  .dn_valid     (dn_valid),
  .dn_ready     (dn_ready),
  .dn_addr      (dn_addr),
  .dn_write     (dn_write),
  .dn_wdata     (dn_wdata),
  .dn_rsp_valid (dn_rsp_valid),
  .rsp_valid    (rsp_valid),
  .rsp_err      (rsp_err),
  .rsp_rdata    (rsp_rdata),
  .viol_pulse   (viol_pulse),
  .viol_addr    (viol_addr),
  .accept_evt   (accept_evt),
  .reject_evt   (reject_evt)
);

// File: tb/sec_bus_filter_tb_top.sv
module sec_bus_filter_tb_top;
  localparam int AW  = 32;
  localparam int DW  = 32;
  localparam int PW  = 3;
  localparam int NSP = 1;

  logic clk = 1'b0;
  logic rst_n;
  logic world_ns, up_valid, up_ready, up_write;
  logic [AW-1:0] up_addr;
  logic [PW-1:0] up_prot;
  logic [DW-1:0] up_wdata;
  logic dn_valid, dn_ready, dn_write;
  logic [AW:0] dn_addr;
  logic [PW-1:0] dn_prot;
  logic [DW-1:0] dn_wdata;
  logic dn_rsp_valid, dn_rsp_err;
  logic [DW-1:0] dn_rsp_rdata;
  logic rsp_valid, rsp_err, viol_pulse;
  logic [DW-1:0] rsp_rdata;
  logic [AW-1:0] viol_addr;

  always #10 clk = ~clk;  // 50 MHz

  sec_bus_filter #(.ADDR_W(AW), .DATA_W(DW), .PROT_W(PW), .NS_POS(NSP)) dut_i (
    .clk(clk), .rst_n(rst_n), .world_ns(world_ns),
    .up_valid(up_valid), .up_ready(up_ready), .up_addr(up_addr), .up_prot(up_prot),
    .up_write(up_write), .up_wdata(up_wdata),
    .dn_valid(dn_valid), .dn_ready(dn_ready), .dn_addr(dn_addr), .dn_prot(dn_prot),
    .dn_write(dn_write), .dn_wdata(dn_wdata),
    .dn_rsp_valid(dn_rsp_valid), .dn_rsp_rdata(dn_rsp_rdata), .dn_rsp_err(dn_rsp_err),
    .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .rsp_err(rsp_err),
    .viol_pulse(viol_pulse), .viol_addr(viol_addr)
  );

  int errors = 0;
  int checks = 0;
  int cycles = 0;

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // Reference arithmetic, restated independently.
  function automatic logic [AW:0] space_addr(input bit ns, input logic [AW-1:0] a);
    logic [AW:0] r;
    r = {1'b0, a};
    r[AW] = ns;
    return r;
  endfunction
  function automatic bit may_access(input bit wns, input bit ns);
    return (wns == 1'b0) || (ns == 1'b1);
  endfunction
  function automatic logic [DW-1:0] blank_fill(input logic [AW:0] a);
    return a[31:0] ^ (a[AW] ? 32'hC3C3_0000 : 32'h0000_3C3C);
  endfunction
  function automatic bit slave_fault(input logic [AW:0] a);
    return a[31:28] == 4'hF;
  endfunction

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired actual=%0d expected<150000", cycles);
      $display("  Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  // Downstream memory model; driven at negedges.
  logic [DW-1:0] smem [logic [AW:0]];
  int hs_count = 0;
  int hs_cycle = 0;
  logic [AW:0] last_addr;
  logic [PW-1:0] last_prot;
  logic last_write;
  logic [DW-1:0] last_wdata;

  initial begin
    logic [AW:0] held_addr;
    logic [DW-1:0] held_wdata;
    logic held_write;
    bit pend;
    bit hold;
    logic [DW-1:0] pend_data;
    bit pend_err;
    pend = 0;
    hold = 0;
    pend_data = '0;
    pend_err = 0;
    held_addr = '0;
    held_wdata = '0;
    held_write = 0;
    dn_ready = 0;
    dn_rsp_valid = 0;
    dn_rsp_rdata = '0;
    dn_rsp_err = 0;
    forever begin
      @(negedge clk);
      dn_rsp_valid = 0;
      if (pend) begin
        dn_rsp_valid = 1;
        dn_rsp_rdata = pend_data;
        dn_rsp_err = pend_err;
        pend = 0;
      end
      if (hold) chk(dn_valid && dn_addr == held_addr && dn_wdata == held_wdata && dn_write == held_write,
                    "R8 stalled request held", {31'b0, dn_addr}, {31'b0, held_addr});
      dn_ready = ($urandom % 3) != 0;
      if (dn_valid && dn_ready) begin
        hs_count++;
        hs_cycle = cycles;
        last_addr = dn_addr;
        last_prot = dn_prot;
        last_write = dn_write;
        last_wdata = dn_wdata;
        pend_data = smem.exists(dn_addr) ? smem[dn_addr] : blank_fill(dn_addr);
        pend_err = slave_fault(dn_addr);
        if (dn_write) smem[dn_addr] = dn_wdata;
        pend = 1;
        hold = 0;
      end else if (dn_valid) begin
        hold = 1;
        held_addr = dn_addr;
        held_wdata = dn_wdata;
        held_write = dn_write;
      end else begin
        hold = 0;
      end
    end
  end

  logic [DW-1:0] rmem [logic [AW:0]];

  task automatic txn(input bit wns, input bit ns, input logic [AW-1:0] addr,
                     input bit wr, input logic [DW-1:0] wd);
    logic [AW:0] ea;
    logic [PW-1:0] prot;
    logic [AW-1:0] va_before;
    logic [DW-1:0] exp;
    int hs0;
    int w;
    bit ok;
    ea = space_addr(ns, addr);
    ok = may_access(wns, ns);
    prot = PW'($urandom);
    prot[NSP] = ns;
    hs0 = hs_count;
    va_before = viol_addr;
    @(negedge clk);
    world_ns = wns; up_valid = 1; up_addr = addr; up_prot = prot; up_write = wr; up_wdata = wd;
    w = 0;
    while (!up_ready && w < 100) begin @(negedge clk); w++; end
    chk(up_ready, "R9 filter idle for new request", {63'b0, up_ready}, 64'd1);
    @(negedge clk);
    up_valid = 0; up_addr = $urandom; up_wdata = $urandom; world_ns = $urandom;
    if (!ok) begin
      chk(rsp_valid && rsp_err && rsp_rdata == '0, "R5 error response next cycle",
          {31'b0, rsp_valid, rsp_err, rsp_rdata}, {31'b0, 2'b11, 32'h0});
      chk(!dn_valid, "R5 no downstream request", {63'b0, dn_valid}, 64'd0);
      chk(viol_pulse && viol_addr == addr, "R6 violation pulse and address",
          {31'b0, viol_pulse, viol_addr}, {31'b0, 1'b1, addr});
      @(negedge clk);
      chk(!viol_pulse, "R6 pulse lasts one cycle", {63'b0, viol_pulse}, 64'd0);
      chk(hs_count == hs0, "R5 no downstream transfer", 64'(hs_count), 64'(hs0));
    end else begin
      chk(!up_ready, "R9 busy while in flight", {63'b0, up_ready}, 64'd0);
      w = 0;
      while (!rsp_valid && w < 100) begin @(negedge clk); w++; end
      chk(hs_count == hs0 + 1, "R3 R4 request forwarded", 64'(hs_count), 64'(hs0 + 1));
      chk(cycles == hs_cycle + 2, "R7 response one cycle after downstream", 64'(cycles), 64'(hs_cycle + 2));
      chk(last_addr == ea, "R2 extended address", {31'b0, last_addr}, {31'b0, ea});
      chk(last_write == wr && last_prot == prot && (!wr || last_wdata == wd), "R10 fields forwarded",
          {28'b0, last_write, last_prot, last_wdata}, {28'b0, wr, prot, wd});
      chk(rsp_err == slave_fault(ea), "R7 error copied", {63'b0, rsp_err}, {63'b0, slave_fault(ea)});
      if (!wr) begin
        exp = rmem.exists(ea) ? rmem[ea] : blank_fill(ea);
        chk(rsp_rdata == exp, wns ? "R4 normal read data" : "R3 space-separated read data",
            {32'b0, rsp_rdata}, {32'b0, exp});
      end else begin
        rmem[ea] = wd;
      end
      chk(viol_addr == va_before, "R6 address held on legal traffic", {32'b0, viol_addr}, {32'b0, va_before});
    end
  endtask

  initial begin
    void'($urandom(32'd2024));
    rst_n = 0; world_ns = 0; up_valid = 0; up_addr = '0; up_prot = '0; up_write = 0; up_wdata = '0;
    repeat (4) @(negedge clk);
    chk(up_ready && !dn_valid && !rsp_valid && !viol_pulse && viol_addr == '0, "R1 reset state",
        {59'b0, up_ready, dn_valid, rsp_valid, viol_pulse, |viol_addr}, {59'b0, 5'b10000});
    rst_n = 1;
    @(negedge clk);
    chk(up_ready && !dn_valid && !rsp_valid && !viol_pulse, "R1 after reset release",
        {60'b0, up_ready, dn_valid, rsp_valid, viol_pulse}, {60'b0, 4'b1000});

    // Directed: aliasing at 0x8000 across the two spaces.
    txn(0, 0, 32'h0000_8000, 1, 32'hAAAA_0001);
    txn(0, 1, 32'h0000_8000, 1, 32'hBBBB_0002);
    txn(0, 0, 32'h0000_8000, 0, '0);
    txn(0, 1, 32'h0000_8000, 0, '0);
    txn(1, 1, 32'h0000_8000, 0, '0);
    // Normal master into secure space: blocked write, then confirm unchanged.
    txn(1, 0, 32'h0000_8000, 1, 32'hDEAD_BEEF);
    txn(0, 0, 32'h0000_8000, 0, '0);
    txn(1, 0, 32'h0000_0044, 0, '0);
    // Back-to-back rejects latch the newest address.
    txn(1, 0, 32'h1234_5678, 0, '0);
    // Downstream error pass-through.
    txn(0, 1, 32'hF000_0010, 0, '0);
    txn(1, 1, 32'hF000_0020, 1, 32'h0BAD_F00D);

    for (int i = 0; i < 400; i++) begin
      logic [AW-1:0] a;
      case ($urandom % 4)
        0: a = 32'h0000_8000;
        1: a = 32'h0000_0100 + 32'($urandom % 8) * 4;
        2: a = 32'hF000_0000 + 32'($urandom % 4) * 4;
        default: a = $urandom;
      endcase
      txn($urandom % 2, $urandom % 2, a, $urandom % 2, $urandom);
    end

    repeat (3) @(negedge clk);
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule